// File: doc/BRIEF.md
# Command/Response Byte FIFO Port

This block is the data path of a single locality of a trusted-module host interface. A host uses a small register bus to push a command into a command byte buffer and to pull the answer back out of a response byte buffer. A five-state machine (idle, ready, reception, execution, completion) and an 8-bit status register control the exchange. The host moves between one and four bytes per bus access.

The FIFO is reachable at several aliased addresses, and all of them reach the same byte stream. While bytes arrive, the block reads the command length from the header and uses it to decide when the packet is complete. A backend drains the command through a byte read port and receives a one-cycle start pulse. It fills the response buffer, then signals that the response is ready, with an optional self-test-done flag. That flag stays in the status register until reset.

Top module: `crb_fifo_port`

## Requirements
- R1: The FIFO answers at offset 0x024 and at every offset from 0x080 to 0x0BF. All of these addresses feed and drain one shared byte stream.
- R2: An access moves min(size, 4 - addr[1:0]) bytes, where `bus_size` is the requested byte count (1, 2 or 4). Written bytes are taken from `bus_wdata` starting at bits 7:0. Read lanes beyond the moved count return 0x00.
- R3: A FIFO read returns successive response bytes in little-endian order. The first byte is in bits 7:0 and each next byte sits 8 bits higher.
- R4: A read byte lane returns 0xFF unless the state is completion and data-available is set. Such lanes consume nothing.
- R5: Reading the last response byte leaves the status at valid (bit 7) plus the sticky self-test bit.
- R6: The first FIFO write in the ready state enters reception and sets the status to valid plus expect (bit 3).
- R7: The command length is the big-endian 32-bit value in header bytes 2 to 5. Expect stays set while fewer than 6 bytes have arrived or while the length exceeds the byte count. Otherwise expect clears. Bytes are stored only while expect is set.
- R8: When the command buffer is full, expect clears and the remaining bytes of that access are discarded.
- R9: FIFO writes are dropped in the idle, execution and completion states. While `loc_active` is low, every FIFO access is ignored and reads return 0xFFFFFFFF.
- R10: Status bit 2 (self-test done) is set by a response-ready strobe that carries `rsp_selftest`. Every other status update keeps it, and only reset clears it.
- R11: Writing retry (bit 1) in completion rewinds the response pointer to zero and restores valid plus data-available (bit 4).
- R12: The status register sits at offset 0x018, and its value reads in bits 7:0. A write with addr[1:0]=0 uses `bus_wdata[7:0]`. Bit 6 (command ready) moves idle, reception or completion to ready with status 0x40 and clears the command buffer. Bit 5 (go) moves reception with expect clear to execution, clears the status and pulses `cmd_start` in the next cycle.
- R13: A response-ready strobe in execution enters completion, sets valid plus data-available, rewinds the read pointer and clears the command count. Reset gives the idle state and status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_active | input | 1 | This locality currently owns the interface |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 3 | Requested byte count |
| bus_wdata | input | 32 | Write data, bytes from bit 0 upward |
| bus_rdata | output | 32 | Read result, valid the cycle after the read |
| sts_o | output | 8 | Status register |
| cmd_start | output | 1 | One-cycle pulse after an accepted go |
| cmd_count | output | CCW | Command bytes held |
| cmd_rd_idx | input | CIW | Backend command byte index |
| cmd_rd_byte | output | 8 | Command byte at `cmd_rd_idx` |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | RIW | Response buffer write index |
| rsp_wdata | input | 8 | Response buffer write byte |
| rsp_ready | input | 1 | Response-ready strobe |
| rsp_len | input | RCW | Response length in bytes |
| rsp_selftest | input | 1 | Response carries self-test done |

## Verification
A wrong write pointer or a wrong captured length shows up as an early or late clear of expect, and `sts_o` shows it in the cycle after the offending write. `cmd_rd_byte` also exposes the misplaced byte at once. A wrong read pointer shows up in the very next `bus_rdata` word as shifted or repeated bytes. A lost self-test bit or a wrong state shows up in the status after the next status update, or when a status write fails to move the machine.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } crb_state_e;

  localparam int STS_VALID    = 7;
  localparam int STS_CRDY     = 6;
  localparam int STS_GO       = 5;
  localparam int STS_AVAIL    = 4;
  localparam int STS_EXPECT   = 3;
  localparam int STS_SELFTEST = 2;
  localparam int STS_RETRY    = 1;

  localparam logic [7:0] NO_DATA  = 8'hFF;
  localparam int HDR_LEN_LO = 2;
  localparam int HDR_LEN_HI = 5;
  localparam int HDR_BYTES  = 6;

  // bytes moved by one access: requested count limited to the 4-byte word
  function automatic logic [2:0] lane_count(input logic [2:0] size, input logic [1:0] lo);
    logic [2:0] room;
    logic [2:0] req;
    room = 3'd4 - {1'b0, lo};
    req  = (size > 3'd4) ? 3'd4 : size;
    return (req < room) ? req : room;
  endfunction

  // bit position of header byte idx inside the big-endian length word
  function automatic int len_shift(input int idx);
    return (HDR_LEN_HI - idx) * 8;
  endfunction

endpackage

// File: rtl/crb_access_decode.sv
module crb_access_decode
  import crb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic              loc_active,
  output logic              fifo_hit,
  output logic              fifo_wr,
  output logic              fifo_rd,
  output logic              sts_hit,
  output logic              sts_wr_lo,
  output logic [2:0]        lanes
);
  localparam logic [ADDR_W-1:0] FIFO_OFS = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] XWIN_LO  = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] XWIN_HI  = ADDR_W'(12'h0BF);
  localparam logic [ADDR_W-1:0] STS_OFS  = ADDR_W'(12'h018);

  logic in_word, in_window;

  assign in_word   = bus_addr[ADDR_W-1:2] == FIFO_OFS[ADDR_W-1:2];
  assign in_window = (bus_addr >= XWIN_LO) && (bus_addr <= XWIN_HI);
  assign fifo_hit  = bus_valid && (in_word || in_window);
  assign fifo_wr   = fifo_hit && bus_write && loc_active;
  assign fifo_rd   = fifo_hit && !bus_write && loc_active;
  assign sts_hit   = bus_valid && (bus_addr[ADDR_W-1:2] == STS_OFS[ADDR_W-1:2]);
  assign sts_wr_lo = sts_hit && bus_write && (bus_addr[1:0] == 2'b00);
  assign lanes     = lane_count(bus_size, bus_addr[1:0]);
endmodule

// File: rtl/crb_cmd_collect.sv
module crb_cmd_collect
  import crb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [2:0]    lanes,
  input  logic [31:0]   wdata,
  input  logic          expect_in,
  output logic          expect_out,
  output logic [CW-1:0] count,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] ptr_q, ptr_d;
  logic [31:0]   len_q, len_d;
  logic [3:0]    we;
  logic [IW-1:0] widx [4];
  logic          ovf, run;

  always_comb begin
    ptr_d = ptr_q;
    len_d = len_q;
    we    = '0;
    ovf   = 1'b0;
    run   = expect_in;
    for (int i = 0; i < 4; i++) begin
      widx[i] = '0;
      if (wr_en && run && (3'(i) < lanes)) begin
        if (ptr_d < CW'(DEPTH)) begin
          we[i]   = 1'b1;
          widx[i] = ptr_d[IW-1:0];
          if (ptr_d >= CW'(HDR_LEN_LO) && ptr_d <= CW'(HDR_LEN_HI))
            len_d[len_shift(int'(ptr_d)) +: 8] = wdata[8*i +: 8];
          ptr_d = ptr_d + 1'b1;
        end else begin
          run = 1'b0;
          ovf = 1'b1;
        end
      end
    end
    expect_out = expect_in && !ovf &&
                 ((ptr_d < CW'(HDR_BYTES)) || (len_d > 32'(ptr_d)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (we[i]) mem[widx[i]] <= wdata[8*i +: 8];
  end

  assign count   = ptr_q;
  assign rd_byte = mem[rd_idx];

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && ptr_q == CW'(DEPTH)) |=> $stable(ptr_q));
  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CW'(DEPTH));
endmodule

// File: rtl/crb_rsp_drain.sv
module crb_rsp_drain
  import crb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_we,
  input  logic [IW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  input  logic          rewind,
  input  logic          rd_en,
  input  logic          serve,
  input  logic          avail_in,
  input  logic [2:0]    lanes,
  output logic [31:0]   rbytes,
  output logic          drained
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] ptr_q, len_q, p;
  logic          run;

  always_comb begin
    p      = ptr_q;
    run    = serve && avail_in;
    rbytes = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < lanes) begin
        if (run && (p < len_q)) begin
          rbytes[8*i +: 8] = mem[p[IW-1:0]];
          p = p + 1'b1;
        end else begin
          rbytes[8*i +: 8] = NO_DATA;
          run = 1'b0;
        end
      end
    end
    drained = serve && avail_in && (lanes != 3'd0) && (p >= len_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (load) begin
      ptr_q <= '0;
      len_q <= (load_len > CW'(DEPTH)) ? CW'(DEPTH) : load_len;
    end else if (rewind) begin
      ptr_q <= '0;
    end else if (rd_en && serve) begin
      ptr_q <= p;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  // R3
  ptr_le_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= len_q);
endmodule

// File: rtl/crb_fifo_port.sv
module crb_fifo_port
  import crb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CMD_DEPTH = 64,
  parameter int RSP_DEPTH = 64,
  parameter int CCW       = $clog2(CMD_DEPTH + 1),
  parameter int CIW       = $clog2(CMD_DEPTH),
  parameter int RCW       = $clog2(RSP_DEPTH + 1),
  parameter int RIW       = $clog2(RSP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_active,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        sts_o,
  output logic              cmd_start,
  output logic [CCW-1:0]    cmd_count,
  input  logic [CIW-1:0]    cmd_rd_idx,
  output logic [7:0]        cmd_rd_byte,
  input  logic              rsp_we,
  input  logic [RIW-1:0]    rsp_waddr,
  input  logic [7:0]        rsp_wdata,
  input  logic              rsp_ready,
  input  logic [RCW-1:0]    rsp_len,
  input  logic              rsp_selftest
);
  localparam logic [7:0] M_VALID  = 8'h80;
  localparam logic [7:0] M_CRDY   = 8'h40;
  localparam logic [7:0] M_AVAIL  = 8'h10;
  localparam logic [7:0] M_EXPECT = 8'h08;

  crb_state_e st_q, st_d;
  logic [7:0]  sts_q, sts_d, fl;
  logic [31:0] rdata_q;
  logic        start_q;

  logic        fifo_hit, fifo_wr, fifo_rd, sts_hit, sts_wr_lo;
  logic [2:0]  lanes;
  logic        exp_out, drained;
  logic [31:0] rbytes;
  logic [7:0]  wb;

  // named internal events
  logic ev_rsp, ev_fifo_wr, ev_drain, ev_crdy, ev_go, ev_retry, ev_st_set;

  crb_access_decode #(.ADDR_W(ADDR_W)) dec_i (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .loc_active(loc_active), .fifo_hit(fifo_hit),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .sts_hit(sts_hit),
    .sts_wr_lo(sts_wr_lo), .lanes(lanes)
  );

  crb_cmd_collect #(.DEPTH(CMD_DEPTH), .CW(CCW), .IW(CIW)) cmd_i (
    .clk(clk), .rst_n(rst_n), .clear(ev_crdy || ev_rsp), .wr_en(ev_fifo_wr),
    .lanes(lanes), .wdata(bus_wdata),
    .expect_in((st_q == ST_READY) || sts_q[STS_EXPECT]),
    .expect_out(exp_out), .count(cmd_count), .rd_idx(cmd_rd_idx),
    .rd_byte(cmd_rd_byte)
  );

  crb_rsp_drain #(.DEPTH(RSP_DEPTH), .CW(RCW), .IW(RIW)) rsp_i (
    .clk(clk), .rst_n(rst_n), .mem_we(rsp_we), .mem_waddr(rsp_waddr),
    .mem_wdata(rsp_wdata), .load(ev_rsp), .load_len(rsp_len),
    .rewind(ev_retry), .rd_en(fifo_rd), .serve(st_q == ST_DONE),
    .avail_in(sts_q[STS_AVAIL]), .lanes(lanes), .rbytes(rbytes),
    .drained(drained)
  );

  assign wb         = bus_wdata[7:0];
  assign ev_rsp     = rsp_ready && (st_q == ST_EXEC);
  assign ev_st_set  = rsp_ready && rsp_selftest;
  assign ev_fifo_wr = fifo_wr && ((st_q == ST_READY) || (st_q == ST_RECV));
  assign ev_drain   = fifo_rd && (st_q == ST_DONE) && drained;
  assign ev_crdy    = sts_wr_lo && wb[STS_CRDY] &&
                      ((st_q == ST_IDLE) || (st_q == ST_RECV) || (st_q == ST_DONE));
  assign ev_go      = sts_wr_lo && !wb[STS_CRDY] && wb[STS_GO] &&
                      (st_q == ST_RECV) && !sts_q[STS_EXPECT];
  assign ev_retry   = sts_wr_lo && !wb[STS_CRDY] && !wb[STS_GO] && wb[STS_RETRY] &&
                      (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    fl   = sts_q;
    if (ev_rsp) begin
      st_d = ST_DONE;
      fl   = M_VALID | M_AVAIL;
    end else if (ev_fifo_wr) begin
      st_d = ST_RECV;
      fl   = M_VALID | (exp_out ? M_EXPECT : 8'h00);
    end else if (ev_drain) begin
      fl   = M_VALID;
    end else if (ev_crdy) begin
      st_d = ST_READY;
      fl   = M_CRDY;
    end else if (ev_go) begin
      st_d = ST_EXEC;
      fl   = 8'h00;
    end else if (ev_retry) begin
      fl   = M_VALID | M_AVAIL;
    end
    sts_d = {fl[7:3], sts_q[STS_SELFTEST] | ev_st_set, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sts_q   <= '0;
      rdata_q <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sts_q   <= sts_d;
      start_q <= ev_go;
      if (bus_valid && !bus_write) begin
        if (fifo_rd)       rdata_q <= rbytes;
        else if (fifo_hit) rdata_q <= 32'hFFFF_FFFF;
        else if (sts_hit)  rdata_q <= {24'h0, sts_q};
        else               rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign sts_o     = sts_q;
  assign cmd_start = start_q;

  // R10
  sticky_selftest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[STS_SELFTEST] |=> sts_q[STS_SELFTEST]);
  // R5
  drain_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drain && !rsp_ready) |=> (sts_q[7:3] == 5'b10000));
  // R9
  done_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_hit && bus_write && st_q == ST_DONE && !rsp_ready) |=> $stable(cmd_count));
  // R9
  inactive_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_hit && !loc_active && !rsp_ready) |=> ($stable(st_q) && $stable(cmd_count)));
  // R12
  start_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (st_q == ST_EXEC));
endmodule

// File: tb/crb_fifo_port_tb_top.sv
module crb_fifo_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_active = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = 3'd1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  sts_o;
  logic        cmd_start;
  logic [6:0]  cmd_count;
  logic [5:0]  cmd_rd_idx = '0;
  logic [7:0]  cmd_rd_byte;
  logic        rsp_we = 1'b0;
  logic [5:0]  rsp_waddr = '0;
  logic [7:0]  rsp_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic [6:0]  rsp_len = '0;
  logic        rsp_selftest = 1'b0;

  int checks = 0, errors = 0, starts = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  crb_fifo_port dut_i (
    .clk(clk), .rst_n(rst_n), .loc_active(loc_active), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_o(sts_o),
    .cmd_start(cmd_start), .cmd_count(cmd_count), .cmd_rd_idx(cmd_rd_idx),
    .cmd_rd_byte(cmd_rd_byte), .rsp_we(rsp_we), .rsp_waddr(rsp_waddr),
    .rsp_wdata(rsp_wdata), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .rsp_selftest(rsp_selftest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // driver: pushes the expected read word, monitor compares it
  task automatic rd(input logic [11:0] a, input logic [2:0] s, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst_n && bus_valid && !bus_write) begin
      #1;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      else chk("monitor queue empty", 32'h1, 32'h0);
    end
  end

  always @(posedge clk) if (rst_n && cmd_start) starts++;

  task automatic cmd_byte(input int idx, input logic [7:0] e, input string tag);
    @(negedge clk);
    cmd_rd_idx = 6'(idx);
    #1;
    chk(tag, {24'h0, cmd_rd_byte}, {24'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset status", {24'h0, sts_o}, 32'h0);
    rd(12'h018, 3'd4, 32'h0, "R12 status read after reset");

    // R12 command ready from idle
    wr(12'h018, 3'd1, 32'h40);
    chk("R12 command ready status", {24'h0, sts_o}, 32'h40);

    // R6 first write: header bytes 0..3
    wr(12'h024, 3'd4, 32'h0000_0180);
    chk("R6 reception status", {24'h0, sts_o}, 32'h88);
    chk("R2 four bytes stored", {25'h0, cmd_count}, 32'd4);
    // R2 boundary: offset 0x82 moves only two bytes (00, 0C) -> length 12
    wr(12'h082, 3'd4, 32'hAABB_0C00);
    chk("R2 boundary cut count", {25'h0, cmd_count}, 32'd6);
    chk("R7 expect while short", {24'h0, sts_o}, 32'h88);
    // R1 window alias
    wr(12'h080, 3'd4, 32'h5443_3221);
    chk("R7 expect while len>count", {24'h0, sts_o}, 32'h88);
    wr(12'h0BC, 3'd2, 32'hFFFF_2211);
    chk("R7 packet complete", {24'h0, sts_o}, 32'h80);
    chk("R7 count at length", {25'h0, cmd_count}, 32'd12);
    cmd_byte(5, 8'h0C, "R1 byte via 0x82 alias");
    cmd_byte(6, 8'h21, "R2 upper lanes not stored");
    cmd_byte(10, 8'h11, "R1 byte via 0xBC alias");
    // R7 nothing stored once expect is clear
    wr(12'h024, 3'd1, 32'h77);
    chk("R7 no store without expect", {25'h0, cmd_count}, 32'd12);

    // R12 go
    wr(12'h018, 3'd1, 32'h20);
    chk("R12 go clears status", {24'h0, sts_o}, 32'h0);
    @(negedge clk);
    chk("R12 start pulse", starts, 1);
    // R4 no data outside completion
    rd(12'h024, 3'd4, 32'hFFFF_FFFF, "R4 exec read no data");
    rd(12'h024, 3'd2, 32'h0000_FFFF, "R2 R4 two lane no data");
    // R9 write dropped in execution
    wr(12'h024, 3'd1, 32'h55);
    chk("R9 exec write dropped", {25'h0, cmd_count}, 32'd12);

    // R13 response ready with self-test
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rsp_we = 1'b1; rsp_waddr = 6'(i); rsp_wdata = 8'hA0 + 8'(i);
    end
    @(negedge clk);
    rsp_we = 1'b0; rsp_ready = 1'b1; rsp_len = 7'd6; rsp_selftest = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0; rsp_selftest = 1'b0;
    chk("R13 R10 completion status", {24'h0, sts_o}, 32'h94);
    chk("R13 command count cleared", {25'h0, cmd_count}, 32'd0);

    rd(12'h024, 3'd1, 32'h0000_00A0, "R3 single byte");
    rd(12'h085, 3'd4, 32'h00A3_A2A1, "R3 R2 three lanes at 0x85");
    chk("R4 still available", {24'h0, sts_o}, 32'h94);
    rd(12'h024, 3'd4, 32'hFFFF_A5A4, "R4 tail lanes no data");
    chk("R5 R10 drained status", {24'h0, sts_o}, 32'h84);
    rd(12'h024, 3'd1, 32'h0000_00FF, "R4 read after drain");

    // R11 retry
    wr(12'h018, 3'd1, 32'h02);
    chk("R11 retry status", {24'h0, sts_o}, 32'h94);
    rd(12'h0A0, 3'd2, 32'h0000_A1A0, "R11 R1 rewound stream");
    // R9 completion write dropped
    wr(12'h024, 3'd1, 32'h66);
    chk("R9 completion write dropped", {25'h0, cmd_count}, 32'd0);
    chk("R9 completion status kept", {24'h0, sts_o}, 32'h94);
    // R9 inactive locality
    loc_active = 1'b0;
    rd(12'h024, 3'd1, 32'hFFFF_FFFF, "R9 inactive read");
    loc_active = 1'b1;
    rd(12'h024, 3'd1, 32'h0000_00A2, "R9 inactive read consumed nothing");

    // R12 R10 command ready from completion keeps self-test
    wr(12'h018, 3'd1, 32'h40);
    chk("R12 R10 ready from completion", {24'h0, sts_o}, 32'h44);

    // R8 overflow: length 256, buffer 64
    wr(12'h024, 3'd4, 32'h0000_0180);
    wr(12'h024, 3'd4, 32'h0000_0001);
    for (int i = 0; i < 14; i++) wr(12'h090, 3'd4, 32'h0102_0304 + 32'(i));
    chk("R8 full count", {25'h0, cmd_count}, 32'd64);
    chk("R7 expect at full", {24'h0, sts_o}, 32'h8C);
    wr(12'h024, 3'd4, 32'hDEAD_BEEF);
    chk("R8 overflow drops expect", {24'h0, sts_o}, 32'h84);
    chk("R8 overflow count held", {25'h0, cmd_count}, 32'd64);
    cmd_byte(63, 8'h01, "R8 last byte intact");

    // R13 R10 reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 R10 reset clears status", {24'h0, sts_o}, 32'h0);
    chk("R13 reset count", {25'h0, cmd_count}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule